// File: doc/BRIEF.md
# ECC page error report aggregator

A page read from flash arrives as a series of packets. A decoder downstream of the flash interface checks each packet and gives three results: whether decoding succeeded, how many bits it corrected, and whether the packet looked erased. This block takes those results one packet at a time, together with the packet's index within the page and a marker on the final packet. From them it builds a 16-bit report word and a page-empty flag for the whole page.

The low byte of the report describes packet 0 and nothing else. The high byte combines every later packet into a single running-maximum correction count and a single pass bit. The block also reduces the two bytes to a page-level verdict: either a failure, or the worst correction count in the page. When every packet of the page was erased, the verdict is forced to clean. All outputs are registered and are presented together with a single-cycle completion strobe.

Top module: `ecc_page_report`

## Requirements
- R1: After reset, `report_o`, `page_max_o`, `page_empty_o`, `page_fail_o` and `done_o` are all zero.
- R2: Bit 7 of `report_o` holds the decode-ok of the page's packet with index 0. Bits 5:0 hold that packet's correction count. Bit 6 is 0.
- R3: Bit 15 of `report_o` is the AND of decode-ok over all packets of the page with index other than 0. It is 1 when there are none. Bits 13:8 hold the largest correction count among those packets, or 0 when there are none. Bit 14 is 0.
- R4: A correction count above 63 is reported as 63 in both report bytes and in `page_max_o`.
- R5: `page_empty_o` is 1 exactly when every accepted packet of the page had `pkt_erased_i` set. In that case `page_fail_o` and `page_max_o` are 0, whatever the report word holds.
- R6: When the page is not empty and either report ok bit (7 or 15) is 0, `page_fail_o` is 1 and `page_max_o` is 0.
- R7: When the page is not empty and both ok bits are 1, `page_fail_o` is 0 and `page_max_o` is the larger of the two report counts.
- R8: `done_o` is high for the single cycle that follows the cycle in which a packet with `pkt_last_i` set is accepted. All result outputs change only in that cycle and hold until the next completion.
- R9: A packet is accepted only when `pkt_valid_i` is high. A packet with index 0 starts a new page and discards the previous page's accumulation. Inputs with `pkt_valid_i` low have no effect.
- R10: A page made of one packet, index 0 with `pkt_last_i` set, reports that packet in the low byte and 0x80 in the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Packet result present this cycle |
| pkt_idx_i | input | IDX_W (4) | Packet index within the page; 0 starts a page |
| pkt_last_i | input | 1 | Final packet of the page |
| pkt_ok_i | input | 1 | Decoder succeeded on the packet |
| pkt_erased_i | input | 1 | Packet looked erased |
| pkt_cnt_i | input | CNT_IN_W (8) | Corrected bits in the packet |
| report_o | output | 16 | Page report word |
| page_empty_o | output | 1 | Whole page was erased |
| page_fail_o | output | 1 | Page uncorrectable |
| page_max_o | output | 6 | Worst correction count of a good page |
| done_o | output | 1 | Results updated this cycle |

## Verification
Packet 0 capture and page completion can fall in the same cycle. This happens when a page has a single packet, or when a one-packet page follows directly behind the last packet of another page with no idle cycle between them. The bench provokes both cases. It checks that the low byte carries the new packet and the high byte shows 0x80 rather than leftovers from the earlier page. It also checks that two completion strobes arrive on consecutive cycles, each with its own results.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;
  localparam int REP_CNT_W = 6;
  localparam int REP_W     = 16;
  localparam int SAT_MAX   = (1 << REP_CNT_W) - 1;

  function automatic logic [REP_CNT_W-1:0] cnt_max(input logic [REP_CNT_W-1:0] a,
                                                  input logic [REP_CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ecc_cnt_sat.sv
module ecc_cnt_sat import ecc_agg_pkg::*; #(
  parameter int IN_W = 8
) (
  input  logic [IN_W-1:0]      cnt_i,
  output logic [REP_CNT_W-1:0] cnt_o
);
  generate
    if (IN_W <= REP_CNT_W) begin : g_narrow
      assign cnt_o = REP_CNT_W'(cnt_i);
    end else begin : g_wide
      logic over;
      assign over  = |cnt_i[IN_W-1:REP_CNT_W];
      assign cnt_o = over ? REP_CNT_W'(SAT_MAX) : cnt_i[REP_CNT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ecc_head_slot.sv
module ecc_head_slot import ecc_agg_pkg::*; #(
  parameter int IN_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 ok_i,
  input  logic [IN_W-1:0]      cnt_raw_i,
  input  logic [REP_CNT_W-1:0] cnt_i,
  output logic                 ok_n_o,
  output logic [REP_CNT_W-1:0] cnt_n_o
);
  logic                 ok_q;
  logic [REP_CNT_W-1:0] cnt_q;

  assign ok_n_o  = load_i ? ok_i  : ok_q;
  assign cnt_n_o = load_i ? cnt_i : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ok_q  <= ok_n_o;
      cnt_q <= cnt_n_o;
    end
  end

  assert_head_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (int'(cnt_raw_i) > SAT_MAX)) |=> (int'(cnt_q) == SAT_MAX));
endmodule

// File: rtl/ecc_tail_fold.sv
module ecc_tail_fold import ecc_agg_pkg::*; (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 first_i,
  input  logic                 ok_i,
  input  logic                 erased_i,
  input  logic [REP_CNT_W-1:0] cnt_i,
  output logic                 ok_n_o,
  output logic [REP_CNT_W-1:0] max_n_o,
  output logic                 erased_n_o
);
  logic                 ok_q;
  logic [REP_CNT_W-1:0] max_q;
  logic                 erased_q;

  always_comb begin
    ok_n_o     = ok_q;
    max_n_o    = max_q;
    erased_n_o = erased_q;
    if (valid_i) begin
      if (first_i) begin
        ok_n_o     = 1'b1;
        max_n_o    = '0;
        erased_n_o = erased_i;
      end else begin
        ok_n_o     = ok_q & ok_i;
        max_n_o    = cnt_max(max_q, cnt_i);
        erased_n_o = erased_q & erased_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q     <= 1'b1;
      max_q    <= '0;
      erased_q <= 1'b0;
    end else begin
      ok_q     <= ok_n_o;
      max_q    <= max_n_o;
      erased_q <= erased_n_o;
    end
  end

  assert_tail_ok_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !first_i && !ok_i) |=> !ok_q);
  assert_tail_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && first_i) |=> (ok_q && max_q == '0));
endmodule

// File: rtl/ecc_page_result.sv
module ecc_page_result import ecc_agg_pkg::*; (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 head_ok_i,
  input  logic [REP_CNT_W-1:0] head_cnt_i,
  input  logic                 tail_ok_i,
  input  logic [REP_CNT_W-1:0] tail_max_i,
  input  logic                 erased_i,
  output logic [REP_W-1:0]     report_o,
  output logic                 empty_o,
  output logic                 fail_o,
  output logic [REP_CNT_W-1:0] max_o,
  output logic                 done_o
);
  logic                 bad;
  logic [REP_CNT_W-1:0] worst;

  assign bad   = !(head_ok_i && tail_ok_i);
  assign worst = cnt_max(head_cnt_i, tail_max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      report_o <= '0;
      empty_o  <= 1'b0;
      fail_o   <= 1'b0;
      max_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) begin
        report_o <= {tail_ok_i, 1'b0, tail_max_i, head_ok_i, 1'b0, head_cnt_i};
        empty_o  <= erased_i;
        fail_o   <= !erased_i && bad;
        max_o    <= (erased_i || bad) ? '0 : worst;
      end
    end
  end

  assert_fail_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (max_o == '0));
  assert_empty_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (!fail_o && max_o == '0));
  assert_done_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> done_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(report_o) && $stable(fail_o) && $stable(empty_o) && $stable(max_o)));
  assert_max_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o && !empty_o) |-> (max_o >= report_o[5:0] && max_o >= report_o[13:8]));
endmodule

// File: rtl/ecc_page_report.sv
module ecc_page_report import ecc_agg_pkg::*; #(
  parameter int IDX_W    = 4,
  parameter int CNT_IN_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pkt_valid_i,
  input  logic [IDX_W-1:0]     pkt_idx_i,
  input  logic                 pkt_last_i,
  input  logic                 pkt_ok_i,
  input  logic                 pkt_erased_i,
  input  logic [CNT_IN_W-1:0]  pkt_cnt_i,
  output logic [REP_W-1:0]     report_o,
  output logic                 page_empty_o,
  output logic                 page_fail_o,
  output logic [REP_CNT_W-1:0] page_max_o,
  output logic                 done_o
);
  logic                 first;
  logic                 head_load;
  logic                 page_end;
  logic [REP_CNT_W-1:0] cnt_sat;
  logic                 head_ok_n, tail_ok_n, erased_n;
  logic [REP_CNT_W-1:0] head_cnt_n, tail_max_n;

  assign first     = (pkt_idx_i == '0);
  assign head_load = pkt_valid_i && first;
  assign page_end  = pkt_valid_i && pkt_last_i;

  ecc_cnt_sat #(.IN_W(CNT_IN_W)) u_sat (
    .cnt_i (pkt_cnt_i),
    .cnt_o (cnt_sat)
  );

  ecc_head_slot #(.IN_W(CNT_IN_W)) u_head (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (head_load),
    .ok_i      (pkt_ok_i),
    .cnt_raw_i (pkt_cnt_i),
    .cnt_i     (cnt_sat),
    .ok_n_o    (head_ok_n),
    .cnt_n_o   (head_cnt_n)
  );

  ecc_tail_fold u_tail (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (pkt_valid_i),
    .first_i    (first),
    .ok_i       (pkt_ok_i),
    .erased_i   (pkt_erased_i),
    .cnt_i      (cnt_sat),
    .ok_n_o     (tail_ok_n),
    .max_n_o    (tail_max_n),
    .erased_n_o (erased_n)
  );

  ecc_page_result u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (page_end),
    .head_ok_i  (head_ok_n),
    .head_cnt_i (head_cnt_n),
    .tail_ok_i  (tail_ok_n),
    .tail_max_i (tail_max_n),
    .erased_i   (erased_n),
    .report_o   (report_o),
    .empty_o    (page_empty_o),
    .fail_o     (page_fail_o),
    .max_o      (page_max_o),
    .done_o     (done_o)
  );

  assert_single_page_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && first && pkt_last_i) |=> (report_o[15:8] == 8'h80));
endmodule

// File: tb/sim_ecc_page_report.sv
`timescale 1ns/1ps
module sim_ecc_page_report;
  typedef struct packed {
    logic [3:0]  idx;
    logic        last;
    logic        ok;
    logic        er;
    logic [7:0]  cnt;
    logic [15:0] rep;
    logic        emp;
    logic        fail;
    logic [5:0]  mx;
  } row_t;

  localparam int NROWS = 18;
  localparam row_t ROWS [NROWS] = '{
    '{4'd0,1'b0,1'b1,1'b0,8'd5,  16'h0000,1'b0,1'b0,6'd0},
    '{4'd1,1'b0,1'b1,1'b0,8'd3,  16'h0000,1'b0,1'b0,6'd0},
    '{4'd2,1'b0,1'b1,1'b0,8'd9,  16'h0000,1'b0,1'b0,6'd0},
    '{4'd3,1'b1,1'b1,1'b0,8'd2,  16'h8985,1'b0,1'b0,6'd9},
    '{4'd0,1'b0,1'b1,1'b0,8'd12, 16'h0000,1'b0,1'b0,6'd0},
    '{4'd1,1'b0,1'b0,1'b0,8'd4,  16'h0000,1'b0,1'b0,6'd0},
    '{4'd2,1'b1,1'b1,1'b0,8'd1,  16'h048C,1'b0,1'b1,6'd0},
    '{4'd0,1'b0,1'b0,1'b0,8'd0,  16'h0000,1'b0,1'b0,6'd0},
    '{4'd1,1'b1,1'b1,1'b0,8'd7,  16'h8700,1'b0,1'b1,6'd0},
    '{4'd0,1'b0,1'b1,1'b0,8'd200,16'h0000,1'b0,1'b0,6'd0},
    '{4'd1,1'b1,1'b1,1'b0,8'd70, 16'hBFBF,1'b0,1'b0,6'd63},
    '{4'd0,1'b0,1'b0,1'b1,8'd0,  16'h0000,1'b0,1'b0,6'd0},
    '{4'd1,1'b1,1'b0,1'b1,8'd0,  16'h0000,1'b1,1'b0,6'd0},
    '{4'd0,1'b0,1'b1,1'b1,8'd0,  16'h0000,1'b0,1'b0,6'd0},
    '{4'd1,1'b1,1'b1,1'b0,8'd2,  16'h8280,1'b0,1'b0,6'd2},
    '{4'd0,1'b1,1'b1,1'b0,8'd11, 16'h808B,1'b0,1'b0,6'd11},
    '{4'd0,1'b0,1'b1,1'b0,8'd20, 16'h0000,1'b0,1'b0,6'd0},
    '{4'd1,1'b1,1'b1,1'b0,8'd6,  16'h8694,1'b0,1'b0,6'd20}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  idx = '0;
  logic        last = 1'b0, ok = 1'b0, er = 1'b0;
  logic [7:0]  cnt = '0;
  logic [15:0] report;
  logic        empty, fail, done;
  logic [5:0]  mx;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ecc_page_report u0 (
    .clk_i(clk), .rst_ni(rst_n), .pkt_valid_i(valid), .pkt_idx_i(idx),
    .pkt_last_i(last), .pkt_ok_i(ok), .pkt_erased_i(er), .pkt_cnt_i(cnt),
    .report_o(report), .page_empty_o(empty), .page_fail_o(fail),
    .page_max_o(mx), .done_o(done)
  );

  task automatic chk(input bit good, input string what, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <5000 cycles", cyc);
      summary();
    end
  end

  task automatic drive(input logic [3:0] i, input logic l, input logic o,
                       input logic e, input logic [7:0] c);
    valid = 1'b1; idx = i; last = l; ok = o; er = e; cnt = c;
  endtask

  task automatic idle_junk(input int k);
    valid = 1'b0; idx = 4'(k); last = 1'b1; ok = k[0]; er = ~k[0]; cnt = 8'(k * 37);
  endtask

  task automatic chk_page(input logic [15:0] r, input logic e, input logic f,
                          input logic [5:0] m);
    chk(done == 1'b1, "R8 done strobe", done, 1);
    chk(report[7:0] == r[7:0], "R2 low byte", report[7:0], r[7:0]);
    chk(report[15:8] == r[15:8], "R3 high byte", report[15:8], r[15:8]);
    chk(empty == e, "R5 empty", empty, e);
    chk(fail == f, "R6 fail", fail, f);
    chk(mx == m, "R7 max", mx, m);
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(report == 16'h0 && mx == 6'd0, "R1 report/max", report, 0);
    chk(!empty && !fail && !done, "R1 flags", {empty, fail, done}, 0);
    rst_n = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      @(negedge clk);
      chk(done == 1'b0, "R8 done single cycle", done, 0);
      drive(ROWS[r].idx, ROWS[r].last, ROWS[r].ok, ROWS[r].er, ROWS[r].cnt);
      @(negedge clk);
      idle_junk(r);   // R9 junk with valid low
      if (ROWS[r].last) chk_page(ROWS[r].rep, ROWS[r].emp, ROWS[r].fail, ROWS[r].mx);
      else chk(done == 1'b0, "R8 no done mid page", done, 0);
    end

    // R9: junk cycles change nothing
    held = report;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      idle_junk(k + 3);
    end
    @(negedge clk);
    chk(report == held && done == 1'b0, "R9 idle ignored", report, held);

    // R4: saturation of a single oversized count
    drive(4'd0, 1'b1, 1'b1, 1'b0, 8'd255);
    @(negedge clk);
    valid = 1'b0;
    chk(report == 16'h80BF && mx == 6'd63, "R4 saturation", report, 16'h80BF);

    // R10: back-to-back pages, second is one packet, no idle gap
    @(negedge clk);
    drive(4'd0, 1'b0, 1'b1, 1'b0, 8'd1);
    @(negedge clk);
    drive(4'd1, 1'b0, 1'b1, 1'b0, 8'd30);
    @(negedge clk);
    drive(4'd2, 1'b1, 1'b1, 1'b0, 8'd2);
    @(negedge clk);
    drive(4'd0, 1'b1, 1'b0, 1'b0, 8'd3);
    chk_page(16'h9E81, 1'b0, 1'b0, 6'd30);
    @(negedge clk);
    valid = 1'b0;
    chk(done == 1'b1, "R10 second done", done, 1);
    chk(report == 16'h8003, "R10 single page report", report, 16'h8003);
    chk(fail == 1'b1 && mx == 6'd0, "R10 single page fail", fail, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done drops", done, 0);

    summary();
  end
endmodule